// File: doc/BRIEF.md
# Message-Signalled Interrupt Capture Controller

This block sits beside a PCIe root port and turns message-signalled interrupt writes into a single level-sensitive interrupt line for the local processor. Software uses a 32-bit register port to do four things. It places a 4 KiB capture window anywhere in a 64-bit address space. It chooses which of 32 vectors may be latched. It masks vectors away from the interrupt line. It clears latched vectors.

A second port carries each inbound memory write as an address and a data word. When the address falls inside the active window, the data word is read as a vector number. The matching status bit is latched if that vector is enabled. The interrupt line stays high while any latched vector is unmasked. Software services the line by writing ones to the status register, which toggles the written bits.

Top module: `msi_capture_ctrl`

## Requirements
- R1: Registers sit at fixed 12-bit offsets: base low 0x820, base high 0x824, vector enable 0x828, vector mask 0x82C, vector status 0x830. Reads return current contents combinationally, and any other offset reads as zero.
- R2: An inbound write hits the window only when the enable register is nonzero and base <= address <= base + 0xFFF. Addresses at base + 0x1000 and at base - 1 miss.
- R3: An inbound write that hits with data value N (N < 32) sets status bit N on the next clock edge, but only if enable bit N is set.
- R4: `irq` is high exactly when some status bit is set whose mask bit is clear. Mask changes do not alter status.
- R5: A register write to the status offset XORs the written word into status. `irq` falls once no unmasked status bit remains, including when status becomes all zero.
- R6: A write to the base low or base high offset replaces only that 32-bit half of the 64-bit base.
- R7: Inbound data values of 32 or more set no status bit.
- R8: The window follows the enable register as it stands before the clock edge. An inbound write in the same cycle as an enable write is decoded with the previous enable value. The new value governs from the next cycle.
- R9: A synchronous active-low reset clears base, enable, mask and status and holds `irq` low.
- R10: When a status write and a capturing inbound write meet in one cycle, the XOR is applied first and the captured bit is then set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| in_valid | input | 1 | Inbound memory write present |
| in_addr | input | 64 | Inbound write byte address |
| in_data | input | 32 | Inbound write data (vector number) |
| irq | output | 1 | Level interrupt |

## Verification
Inbound writes are aimed at both sides of each window edge, at base - 1, base, base + 0xFFF and base + 0x1000, which separates an off-by-one in the window compare from a correct one. Data values of 31 and 32 separate a vector-range check from a bit-index wrap. Enabled versus disabled vectors, and masked versus unmasked status, show whether the gating follows enable and mask independently. Random runs mix enable, mask, status-toggle and inbound traffic, including writes that collide in one cycle, so the ordering rules for enable timing and for XOR before capture are exercised against the bench model.

// File: rtl/msi_cap_pkg.sv
// Package: register offsets and decode for the interrupt capture controller.
// Assumes a 12-bit byte offset on the register port and 32-bit registers.
package msi_cap_pkg;

    localparam int REG_AW = 12;

    localparam logic [REG_AW-1:0] OFS_BASE_LO = 12'h820;
    localparam logic [REG_AW-1:0] OFS_BASE_HI = 12'h824;
    localparam logic [REG_AW-1:0] OFS_ENABLE  = 12'h828;
    localparam logic [REG_AW-1:0] OFS_MASK    = 12'h82C;
    localparam logic [REG_AW-1:0] OFS_STATUS  = 12'h830;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_BASE_LO,
        SEL_BASE_HI,
        SEL_ENABLE,
        SEL_MASK,
        SEL_STATUS
    } reg_sel_e;

    // Map a byte offset to the register it names.
    function automatic reg_sel_e decode_offset(input logic [REG_AW-1:0] ofs);
        case (ofs)
            OFS_BASE_LO: decode_offset = SEL_BASE_LO;
            OFS_BASE_HI: decode_offset = SEL_BASE_HI;
            OFS_ENABLE:  decode_offset = SEL_ENABLE;
            OFS_MASK:    decode_offset = SEL_MASK;
            OFS_STATUS:  decode_offset = SEL_STATUS;
            default:     decode_offset = SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/msi_cap_regs.sv
// Register file: holds the capture base, the vector enable and the vector mask.
// Turns status-offset writes into a toggle request for the vector bank.
// Read data is combinational from the current register contents.
// Assumes BASE_W is a whole number of DATA_W words (two by default).
module msi_cap_regs
    import msi_cap_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int BASE_W  = 64,
    parameter int NUM_VEC = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    input  logic [NUM_VEC-1:0]  status_q,
    output logic [BASE_W-1:0]   base_q,
    output logic [NUM_VEC-1:0]  enable_q,
    output logic [NUM_VEC-1:0]  mask_q,
    output logic                status_wr,
    output logic [NUM_VEC-1:0]  status_xor,
    output logic [DATA_W-1:0]   reg_rdata
);
    localparam int NUM_HALF = BASE_W / DATA_W;

    reg_sel_e sel;

    // Decode the offset once for both write and read paths.
    always_comb sel = decode_offset(reg_addr);

    // One DATA_W slice of the base per generate step; each slice has its own offset.
    for (genvar h = 0; h < NUM_HALF; h++) begin : g_base
        logic hit_half;
        always_comb hit_half = reg_wr &&
                               (((h == 0) && (sel == SEL_BASE_LO)) ||
                                ((h == 1) && (sel == SEL_BASE_HI)));
        // Capture the written word into this slice only.
        always_ff @(posedge clk) begin
            if (!rst_n)
                base_q[h*DATA_W +: DATA_W] <= '0;
            else if (hit_half)
                base_q[h*DATA_W +: DATA_W] <= reg_wdata;
        end
    end

    // Vector enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            enable_q <= '0;
        else if (reg_wr && sel == SEL_ENABLE)
            enable_q <= reg_wdata[NUM_VEC-1:0];
    end

    // Vector mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (reg_wr && sel == SEL_MASK)
            mask_q <= reg_wdata[NUM_VEC-1:0];
    end

    // Status writes pass straight to the vector bank as a toggle request.
    always_comb begin
        status_wr  = reg_wr && (sel == SEL_STATUS);
        status_xor = reg_wdata[NUM_VEC-1:0];
    end

    // Read multiplexer; unmapped offsets return zero.
    always_comb begin
        reg_rdata = '0;
        case (sel)
            SEL_BASE_LO: reg_rdata = base_q[DATA_W-1:0];
            SEL_BASE_HI: reg_rdata = base_q[NUM_HALF*DATA_W-1 -: DATA_W];
            SEL_ENABLE:  reg_rdata[NUM_VEC-1:0] = enable_q;
            SEL_MASK:    reg_rdata[NUM_VEC-1:0] = mask_q;
            SEL_STATUS:  reg_rdata[NUM_VEC-1:0] = status_q;
            default:     reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/msi_cap_window.sv
// Window decoder: flags an inbound write whose address lies in
// [base, base + WIN_BYTES - 1] while any vector is enabled.
// Uses one BASE_W+1 bit subtract, so a window that runs past the top of the
// address space never aliases onto low addresses.
module msi_cap_window #(
    parameter int BASE_W    = 64,
    parameter int NUM_VEC   = 32,
    parameter int WIN_BYTES = 4096
) (
    input  logic               in_valid,
    input  logic [BASE_W-1:0]  in_addr,
    input  logic [BASE_W-1:0]  base_q,
    input  logic [NUM_VEC-1:0] enable_q,
    output logic               hit
);
    localparam logic [BASE_W-1:0] WIN_SIZE = BASE_W'(WIN_BYTES);

    logic [BASE_W:0] offset;
    logic            below_base;
    logic            win_active;

    // Distance from the base; the top bit is the borrow for addresses below it.
    always_comb begin
        offset     = {1'b0, in_addr} - {1'b0, base_q};
        below_base = offset[BASE_W];
        win_active = |enable_q;
        hit        = in_valid && win_active && !below_base &&
                     (offset[BASE_W-1:0] < WIN_SIZE);
    end

endmodule

// File: rtl/msi_cap_vectors.sv
// Vector bank: one status flop per vector plus the level interrupt.
// A hit with data N sets bit N if enabled. A status write toggles bits.
// When both occur in one cycle, the toggle is applied first and then the set.
// Assumes data values of NUM_VEC or more name no vector.
module msi_cap_vectors #(
    parameter int DATA_W  = 32,
    parameter int NUM_VEC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hit,
    input  logic [DATA_W-1:0]  in_data,
    input  logic [NUM_VEC-1:0] enable_q,
    input  logic [NUM_VEC-1:0] mask_q,
    input  logic               status_wr,
    input  logic [NUM_VEC-1:0] status_xor,
    output logic [NUM_VEC-1:0] status_q,
    output logic               irq
);
    // One flop and its set term per vector.
    for (genvar i = 0; i < NUM_VEC; i++) begin : g_vec
        logic set_i;
        logic tog_i;
        // This vector is named by the data word and allowed by enable.
        always_comb begin
            set_i = hit && (in_data == DATA_W'(i)) && enable_q[i];
            tog_i = status_wr && status_xor[i];
        end
        // Toggle from software first, capture wins afterwards.
        always_ff @(posedge clk) begin
            if (!rst_n)
                status_q[i] <= 1'b0;
            else
                status_q[i] <= (status_q[i] ^ tog_i) | set_i;
        end
    end

    // Level interrupt from any unmasked pending vector.
    always_comb irq = |(status_q & ~mask_q);

endmodule

// File: rtl/msi_capture_ctrl.sv
// Top: message-signalled interrupt capture controller.
// Joins the register file, the window decoder and the vector bank.
// Assumes one register access and one inbound write at most per cycle.
module msi_capture_ctrl
    import msi_cap_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int BASE_W    = 64,
    parameter int NUM_VEC   = 32,
    parameter int WIN_BYTES = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [11:0]       reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              in_valid,
    input  logic [63:0]       in_addr,
    input  logic [31:0]       in_data,
    output logic              irq
);
    logic [BASE_W-1:0]  base_q;
    logic [NUM_VEC-1:0] enable_q;
    logic [NUM_VEC-1:0] mask_q;
    logic [NUM_VEC-1:0] status_q;
    logic [NUM_VEC-1:0] status_xor;
    logic               status_wr;
    logic               win_hit;

    msi_cap_regs #(
        .DATA_W (DATA_W),
        .BASE_W (BASE_W),
        .NUM_VEC(NUM_VEC)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .status_q  (status_q),
        .base_q    (base_q),
        .enable_q  (enable_q),
        .mask_q    (mask_q),
        .status_wr (status_wr),
        .status_xor(status_xor),
        .reg_rdata (reg_rdata)
    );

    msi_cap_window #(
        .BASE_W   (BASE_W),
        .NUM_VEC  (NUM_VEC),
        .WIN_BYTES(WIN_BYTES)
    ) u_window (
        .in_valid(in_valid),
        .in_addr (in_addr),
        .base_q  (base_q),
        .enable_q(enable_q),
        .hit     (win_hit)
    );

    msi_cap_vectors #(
        .DATA_W (DATA_W),
        .NUM_VEC(NUM_VEC)
    ) u_vectors (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit       (win_hit),
        .in_data   (in_data),
        .enable_q  (enable_q),
        .mask_q    (mask_q),
        .status_wr (status_wr),
        .status_xor(status_xor),
        .status_q  (status_q),
        .irq       (irq)
    );

endmodule

// File: rtl/msi_capture_chk.sv
// Checker: temporal properties of the capture controller, bound to the top.
// Observes top-level ports and the registered state between the submodules.
module msi_capture_chk #(
    parameter int NUM_VEC = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_wr,
    input logic [11:0]        reg_addr,
    input logic [31:0]        reg_wdata,
    input logic               in_valid,
    input logic [31:0]        in_data,
    input logic               irq,
    input logic               win_hit,
    input logic [63:0]        base_q,
    input logic [NUM_VEC-1:0] enable_q,
    input logic [NUM_VEC-1:0] status_q
);
    localparam int IDX_W = $clog2(NUM_VEC);

    logic st_wr;
    always_comb st_wr = reg_wr && (reg_addr == 12'h830);

    // R9: reset leaves status clear and the line low.
    p_reset_clear_r9: assert property (@(posedge clk)
        !rst_n |=> (status_q == '0) && !irq);

    // R4: the line is never high without a pending vector.
    p_irq_needs_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status_q != '0));

    // R3: an enabled, in-window vector is latched on the next edge.
    p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (win_hit && (in_data < NUM_VEC) && enable_q[in_data[IDX_W-1:0]])
        |=> status_q[$past(in_data[IDX_W-1:0])]);

    // R3: without a status write or a window hit, status holds.
    p_status_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_wr && !win_hit) |=> $stable(status_q));

    // R7: out-of-range vector numbers change nothing.
    p_big_vector_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_data >= NUM_VEC) && !st_wr) |=> $stable(status_q));

    // R5: a status write alone toggles exactly the written bits.
    p_status_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr && !in_valid)
        |=> status_q == ($past(status_q) ^ $past(reg_wdata[NUM_VEC-1:0])));

    // R6: writing the low half leaves the high half unchanged.
    p_base_lo_half_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 12'h820) |=> $stable(base_q[63:32]));

    // R2: a disabled window never hits.
    p_window_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_q == '0) |-> !win_hit);

endmodule

bind msi_capture_ctrl msi_capture_chk #(.NUM_VEC(NUM_VEC)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .in_valid (in_valid),
    .in_data  (in_data),
    .irq      (irq),
    .win_hit  (win_hit),
    .base_q   (base_q),
    .enable_q (enable_q),
    .status_q (status_q)
);

// File: tb/test_msi_capture_ctrl.sv
// Bench: directed corner cases plus seeded random traffic against a bench model.
module test_msi_capture_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        in_valid = 1'b0;
    logic [63:0] in_addr = '0;
    logic [31:0] in_data = '0;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    localparam logic [11:0] A_LO = 12'h820, A_HI = 12'h824, A_EN = 12'h828,
                            A_MK = 12'h82C, A_ST = 12'h830;

    logic [63:0] m_base = '0;
    logic [31:0] m_en = '0, m_mask = '0, m_st = '0;

    always #2.5 clk = ~clk;

    msi_capture_ctrl i_msi_capture_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_valid(in_valid),
        .in_addr(in_addr), .in_data(in_data), .irq(irq)
    );

    function automatic bit model_hit(input logic [63:0] a);
        return (m_en != 0) && (a >= m_base) && ((a - m_base) < 64'h1000);
    endfunction

    function automatic bit model_irq();
        return |(m_st & ~m_mask);
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    // One cycle with an optional register write and an optional inbound write.
    task automatic step(input bit dr, input logic [11:0] ra, input logic [31:0] rv,
                        input bit di, input logic [63:0] ia, input logic [31:0] id);
        logic [31:0] setm;
        @(negedge clk);
        reg_wr = dr; reg_addr = ra; reg_wdata = rv;
        in_valid = di; in_addr = ia; in_data = id;
        setm = '0;
        if (di && model_hit(ia) && id < 32 && m_en[id[4:0]]) setm[id[4:0]] = 1'b1;
        if (dr) begin
            case (ra)
                A_LO: m_base[31:0] = rv;
                A_HI: m_base[63:32] = rv;
                A_EN: m_en = rv;
                A_MK: m_mask = rv;
                A_ST: m_st = m_st ^ rv;
                default: ;
            endcase
        end
        m_st = m_st | setm;
        @(negedge clk);
        reg_wr = 1'b0; in_valid = 1'b0;
    endtask

    task automatic wreg(input logic [11:0] a, input logic [31:0] v);
        step(1'b1, a, v, 1'b0, '0, '0);
    endtask

    task automatic inb(input logic [63:0] a, input logic [31:0] d);
        step(1'b0, '0, '0, 1'b1, a, d);
    endtask

    task automatic check_state(input string req);
        logic [31:0] v;
        check(req, irq, model_irq());
        rd(A_ST, v);
        check(req, v, m_st);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [63:0] b;
        void'($urandom(32'h5EED1234));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 / R1: reset state and unmapped read
        check("R9 irq", irq, 0);
        rd(A_LO, v); check("R9 base lo", v, 0);
        rd(A_HI, v); check("R9 base hi", v, 0);
        rd(A_EN, v); check("R9 enable", v, 0);
        rd(A_MK, v); check("R9 mask", v, 0);
        rd(A_ST, v); check("R9 status", v, 0);

        // R6: halves written independently
        wreg(A_LO, 32'hABCD_E000);
        wreg(A_HI, 32'h0000_0077);
        rd(A_LO, v); check("R6 low kept", v, 32'hABCD_E000);
        wreg(A_LO, 32'h1234_5000);
        rd(A_HI, v); check("R6 high kept", v, 32'h0000_0077);
        rd(A_LO, v); check("R1 base lo read", v, 32'h1234_5000);
        rd(12'h834, v); check("R1 unmapped zero", v, 0);
        rd(12'h000, v); check("R1 unmapped zero low", v, 0);
        b = m_base;

        // R2: window off while enable is zero
        inb(b, 32'd3);
        check_state("R2 disabled window");

        // R8: enable write and inbound in one cycle use the old enable
        step(1'b1, A_EN, 32'h8000_00FF, 1'b1, b, 32'd1);
        check_state("R8 same-cycle enable");
        rd(A_EN, v); check("R1 enable read", v, 32'h8000_00FF);
        inb(b, 32'd1);
        check_state("R8 next-cycle enable");

        // R2: window edges
        inb(b + 64'hFFF, 32'd2);
        check_state("R2 top edge hit");
        inb(b + 64'h1000, 32'd3);
        check_state("R2 past end miss");
        inb(b - 64'd1, 32'd4);
        check_state("R2 below base miss");

        // R3: disabled vector not latched; R7: out-of-range values ignored
        inb(b + 64'h10, 32'd20);
        check_state("R3 disabled vector");
        inb(b + 64'h10, 32'd31);
        check_state("R3 vector 31");
        inb(b + 64'h10, 32'd32);
        check_state("R7 data 32");
        inb(b + 64'h10, 32'h0000_0101);
        check_state("R7 data 257");

        // R4: mask hides pending bits without clearing them
        wreg(A_MK, 32'hFFFF_FFFF);
        check_state("R4 all masked");
        wreg(A_MK, 32'h0000_0002);
        check_state("R4 partial mask");
        rd(A_MK, v); check("R1 mask read", v, 32'h0000_0002);

        // R5: XOR clear, line drops when empty
        wreg(A_ST, 32'h8000_0000);
        check_state("R5 partial clear");
        wreg(A_ST, m_st);
        check_state("R5 full clear");
        check("R5 irq low", irq, 0);

        // R10: toggle and capture of the same bit together: capture wins
        wreg(A_ST, 32'h0000_0001);
        check_state("R5 xor sets");
        step(1'b1, A_ST, 32'h0000_0001, 1'b1, b + 64'h20, 32'd0);
        check_state("R10 capture after toggle");
        check("R10 bit0", m_st[0], 1'b1);

        // Random traffic
        wreg(A_ST, m_st);
        for (int k = 0; k < 600; k++) begin
            int op;
            logic [63:0] a;
            op = int'($urandom % 8);
            a = b + 64'($urandom % 32'h1200) - 64'h100;
            case (op)
                0: wreg(A_EN, ($urandom % 4 == 0) ? 32'h0 : $urandom);
                1: wreg(A_MK, $urandom & $urandom);
                2: wreg(A_ST, $urandom & $urandom);
                7: step(1'b1, ($urandom % 2) ? A_ST : A_EN, $urandom, 1'b1, a, $urandom % 40);
                default: inb(a, $urandom % 40);
            endcase
            check_state("R3 R4 random");
        end

        // R9: reset in the middle of activity
        wreg(A_MK, 32'h0);
        inb(b + 64'h8, 32'd7);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        m_base = '0; m_en = '0; m_mask = '0; m_st = '0;
        check_state("R9 reset clears");
        rd(A_EN, v); check("R9 enable cleared", v, 0);
        rd(A_HI, v); check("R9 base cleared", v, 0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule